// File: doc/BRIEF.md
# Parallel NOR Flash Erase Sequencer

This block runs erase operations on an 8-bit asynchronous parallel NOR flash without processor help. A one-cycle start pulse, together with an erase-all select, a sector address and a base address, launches one operation. The sequencer then issues six command writes. Five of them are the fixed unlock and setup cycles. The sixth depends on the mode: it erases either the whole device or the chosen sector.

After the command the block polls the device's status byte. Bit 7 reading back as 1 means the erase is complete, because an erased byte reads 0xFF. Bit 5 is the device's time-limit flag: when it is seen, the block makes exactly one more read to decide between success and failure. The number of poll reads is capped by a parameter. Whatever the outcome, the block writes the reset command 0xF0 at the base address so the device returns to read-array mode. It then pulses either done or error for one cycle.

Every bus cycle holds address and data steady while the strobe is high. Write strobes and read strobes each last a programmable number of clocks. Idle clocks separate consecutive strobes.

Top module: `nor_erase_seq`

## Requirements
- R1: After reset, busy_o, done_o, error_o, fl_we_o and fl_oe_o are all 0, and both strobes stay low whenever busy_o is 0.
- R2: The first five write cycles of every operation are, in order: 0xAA at base+0x555, 0x55 at base+0x2AA, 0x80 at base+0x555, 0xAA at base+0x555, 0x55 at base+0x2AA. Addition is modulo 2^ADDR_W.
- R3: With erase_all_i=1 at start, the sixth write is 0x10 at base+0x555.
- R4: With erase_all_i=0 at start, the sixth write is 0x30 at the sector address.
- R5: After the sixth write the block reads the poll address. This is the sector address in sector mode and the base address in whole-chip mode. A read with bit 7 = 1 ends polling with success (done_o).
- R6: A poll read with bit 7 = 0 and bit 5 = 1 is followed by exactly one further read. The operation succeeds if that read has bit 7 = 1 and fails (error_o) otherwise.
- R7: If POLL_LIMIT consecutive poll reads all have bits 7 and 5 clear, polling stops and the operation fails.
- R8: The last bus cycle of every operation, successful or failed, is a write of 0xF0 at the base address. An operation makes exactly seven writes.
- R9: Each write strobe stays high for exactly WR_PULSE clocks, with address and data stable. The strobes are never high together. At least one clock with both strobes low separates consecutive strobes.
- R10: Each read strobe stays high for exactly RD_PULSE clocks. The status byte is sampled in the last of those clocks.
- R11: busy_o rises in the cycle after an accepted start and falls in the cycle where done_o or error_o pulses. Each operation produces exactly one single-cycle pulse on exactly one of them. A start pulse while busy_o is 1 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | One-cycle request to begin an erase |
| erase_all_i | input | 1 | 1 selects whole-chip erase, 0 selects sector erase |
| sector_addr_i | input | ADDR_W | Sector address used for sector erase and its polling |
| base_addr_i | input | ADDR_W | Device base address for command offsets |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle pulse: erase succeeded |
| error_o | output | 1 | One-cycle pulse: erase failed or timed out |
| fl_addr_o | output | ADDR_W | Flash address bus |
| fl_dq_o | output | 8 | Flash write data |
| fl_dq_i | input | 8 | Flash read data |
| fl_we_o | output | 1 | Write strobe, active high |
| fl_oe_o | output | 1 | Read strobe, active high |

## Verification
Both erase modes are swept against devices that report completion after zero to three busy reads, using several base and sector addresses. This separates mode-dependent command data and poll address from fixed unlock traffic, and shows that the poll count follows the device rather than a fixed count. Status streams with bit 5 set followed by a good or bad recheck read distinguish the single-recheck rule from both plain polling and an immediate failure. A device that never finishes exercises the read cap. A second start issued mid-operation with the opposite mode and another sector shows that the running command sequence is left untouched.

// File: rtl/nes_pkg.sv
// Package for the NOR erase sequencer.
// Holds command constants, the controller state type and the
// function that maps a command step to its offset and data.
// Assumes an 8-bit device data bus.
package nes_pkg;

    localparam logic [7:0]  CMD_KEY_A  = 8'hAA;
    localparam logic [7:0]  CMD_KEY_B  = 8'h55;
    localparam logic [7:0]  CMD_SETUP  = 8'h80;
    localparam logic [7:0]  CMD_CHIP   = 8'h10;
    localparam logic [7:0]  CMD_SECTOR = 8'h30;
    localparam logic [7:0]  CMD_RESET  = 8'hF0;
    localparam logic [11:0] OFS_HI     = 12'h555;
    localparam logic [11:0] OFS_LO     = 12'h2AA;
    localparam logic [2:0]  STEP_LAST  = 3'd5;
    localparam logic [2:0]  STEP_RESET = 3'd6;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CMD,
        ST_POLL,
        ST_RECHECK,
        ST_RESET
    } seq_state_t;

    typedef struct packed {
        logic        at_sector;
        logic [11:0] offset;
        logic [7:0]  data;
    } cmd_word_t;

    // Offset and data for one command step; step 6 is the reset write.
    function automatic cmd_word_t cmd_word(input logic [2:0] step, input logic whole);
        cmd_word_t w;
        w.at_sector = 1'b0;
        w.offset    = OFS_HI;
        w.data      = CMD_RESET;
        case (step)
            3'd0: begin w.offset = OFS_HI; w.data = CMD_KEY_A; end
            3'd1: begin w.offset = OFS_LO; w.data = CMD_KEY_B; end
            3'd2: begin w.offset = OFS_HI; w.data = CMD_SETUP; end
            3'd3: begin w.offset = OFS_HI; w.data = CMD_KEY_A; end
            3'd4: begin w.offset = OFS_LO; w.data = CMD_KEY_B; end
            3'd5: begin
                if (whole) begin
                    w.offset = OFS_HI;
                    w.data   = CMD_CHIP;
                end else begin
                    w.at_sector = 1'b1;
                    w.offset    = 12'h000;
                    w.data      = CMD_SECTOR;
                end
            end
            default: begin w.offset = 12'h000; w.data = CMD_RESET; end
        endcase
        return w;
    endfunction

endpackage

// File: rtl/nes_cmd_table.sv
// Command table: turns a step number into a bus address and data byte.
// Purely combinational. Assumes ADDR_W >= 12 so offsets fit.
module nes_cmd_table #(
    parameter int ADDR_W = 20
) (
    input  logic [2:0]        step_i,
    input  logic              whole_i,
    input  logic [ADDR_W-1:0] base_i,
    input  logic [ADDR_W-1:0] sector_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic [7:0]        data_o
);
    import nes_pkg::*;

    cmd_word_t word;

    // Look up the step and form the absolute address.
    always_comb begin
        word   = cmd_word(step_i, whole_i);
        data_o = word.data;
        if (word.at_sector)
            addr_o = sector_i;
        else
            addr_o = base_i + ADDR_W'(word.offset);
    end

endmodule

// File: rtl/nes_bus_cycle.sv
// Bus-cycle engine: runs one write or read cycle per request.
// Address and data are registered on the request and held.
// The strobe lasts WR_PULSE or RD_PULSE clocks. One gap clock follows,
// in which ack_o pulses and, for reads, rdata_o is valid.
// Assumes req_i is raised only while ready_o is 1.
module nes_bus_cycle #(
    parameter int ADDR_W   = 20,
    parameter int WR_PULSE = 3,
    parameter int RD_PULSE = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_i,
    input  logic              rd_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [7:0]        wdata_i,
    input  logic [7:0]        fl_dq_i,
    output logic              ready_o,
    output logic              ack_o,
    output logic [7:0]        rdata_o,
    output logic [ADDR_W-1:0] fl_addr_o,
    output logic [7:0]        fl_dq_o,
    output logic              fl_we_o,
    output logic              fl_oe_o
);
    localparam int MAX_PULSE = (WR_PULSE > RD_PULSE) ? WR_PULSE : RD_PULSE;
    localparam int CNT_W     = $clog2(MAX_PULSE + 1);
    localparam logic [CNT_W-1:0] WR_LIM = CNT_W'(WR_PULSE);
    localparam logic [CNT_W-1:0] RD_LIM = CNT_W'(RD_PULSE);

    typedef enum logic [1:0] {PH_IDLE, PH_STROBE, PH_GAP} phase_t;

    phase_t           phase;
    logic [CNT_W-1:0] cnt;
    logic             is_rd;
    logic [CNT_W-1:0] limit;

    // Pick the strobe length of the cycle in flight.
    always_comb limit = is_rd ? RD_LIM : WR_LIM;

    // Sequence one bus cycle and capture read data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase     <= PH_IDLE;
            cnt       <= '0;
            is_rd     <= 1'b0;
            fl_addr_o <= '0;
            fl_dq_o   <= '0;
            fl_we_o   <= 1'b0;
            fl_oe_o   <= 1'b0;
            rdata_o   <= '0;
        end else begin
            case (phase)
                PH_IDLE: begin
                    if (req_i) begin
                        fl_addr_o <= addr_i;
                        fl_dq_o   <= rd_i ? 8'h00 : wdata_i;
                        is_rd     <= rd_i;
                        fl_we_o   <= !rd_i;
                        fl_oe_o   <= rd_i;
                        cnt       <= CNT_W'(1);
                        phase     <= PH_STROBE;
                    end
                end
                PH_STROBE: begin
                    if (cnt == limit) begin
                        fl_we_o <= 1'b0;
                        fl_oe_o <= 1'b0;
                        if (is_rd)
                            rdata_o <= fl_dq_i;
                        phase <= PH_GAP;
                    end else begin
                        cnt <= cnt + CNT_W'(1);
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    assign ready_o = (phase == PH_IDLE);
    assign ack_o   = (phase == PH_GAP);

endmodule

// File: rtl/nes_poll_judge.sv
// Poll judge: classifies each status read and counts poll reads.
// complete_o: bit 7 matches the erased value 1.
// limit_o: bit 5 (device time limit) is set.
// last_o: the current read is the POLL_LIMIT-th since clear.
module nes_poll_judge #(
    parameter int POLL_LIMIT = 70000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr_i,
    input  logic       sample_i,
    input  logic [7:0] status_i,
    output logic       complete_o,
    output logic       limit_o,
    output logic       last_o
);
    localparam int CNT_W = $clog2(POLL_LIMIT + 1);
    localparam logic [7:0]       EXPECT   = 8'hFF;
    localparam logic [7:0]       DONE_BIT = 8'h80;
    localparam logic [7:0]       TIME_BIT = 8'h20;
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(POLL_LIMIT - 1);

    logic [CNT_W-1:0] reads;

    // Compare status bits against the expected erased byte.
    always_comb begin
        complete_o = ((status_i ^ EXPECT) & DONE_BIT) == 8'h00;
        limit_o    = (status_i & TIME_BIT) != 8'h00;
        last_o     = (reads == LAST_IDX);
    end

    // Count poll reads in the current operation.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i)
            reads <= '0;
        else if (sample_i && !last_o)
            reads <= reads + CNT_W'(1);
    end

endmodule

// File: rtl/nor_erase_seq.sv
// NOR erase sequencer top. Accepts a start pulse, sends the six-cycle
// erase command, polls status with a time-limit recheck and a read cap,
// writes the reset command, then pulses done or error.
// Assumes ADDR_W >= 12, WR_PULSE >= 1, RD_PULSE >= 1, POLL_LIMIT >= 1.
module nor_erase_seq #(
    parameter int ADDR_W     = 20,
    parameter int WR_PULSE   = 3,
    parameter int RD_PULSE   = 2,
    parameter int POLL_LIMIT = 70000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              erase_all_i,
    input  logic [ADDR_W-1:0] sector_addr_i,
    input  logic [ADDR_W-1:0] base_addr_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              error_o,
    output logic [ADDR_W-1:0] fl_addr_o,
    output logic [7:0]        fl_dq_o,
    input  logic [7:0]        fl_dq_i,
    output logic              fl_we_o,
    output logic              fl_oe_o
);
    import nes_pkg::*;

    seq_state_t        state;
    logic [2:0]        step;
    logic              whole_q;
    logic [ADDR_W-1:0] base_q;
    logic [ADDR_W-1:0] sector_q;
    logic              issued;
    logic              fail_q;

    logic              eng_req, eng_rd, eng_ready, eng_ack;
    logic [ADDR_W-1:0] eng_addr, tbl_addr;
    logic [7:0]        tbl_data, eng_rdata;
    logic [2:0]        tbl_step;
    logic              st_complete, st_limit, st_last;
    logic              accept, issuing;

    // Decide when a new bus cycle is requested and what it carries.
    always_comb begin
        accept   = (state == ST_IDLE) && start_i;
        issuing  = (state != ST_IDLE);
        eng_rd   = (state == ST_POLL) || (state == ST_RECHECK);
        eng_req  = issuing && eng_ready && !issued;
        tbl_step = (state == ST_RESET) ? STEP_RESET : step;
        eng_addr = eng_rd ? (whole_q ? base_q : sector_q) : tbl_addr;
    end

    nes_cmd_table #(.ADDR_W(ADDR_W)) u_table (
        .step_i   (tbl_step),
        .whole_i  (whole_q),
        .base_i   (base_q),
        .sector_i (sector_q),
        .addr_o   (tbl_addr),
        .data_o   (tbl_data)
    );

    nes_bus_cycle #(
        .ADDR_W   (ADDR_W),
        .WR_PULSE (WR_PULSE),
        .RD_PULSE (RD_PULSE)
    ) u_bus (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_i     (eng_req),
        .rd_i      (eng_rd),
        .addr_i    (eng_addr),
        .wdata_i   (tbl_data),
        .fl_dq_i   (fl_dq_i),
        .ready_o   (eng_ready),
        .ack_o     (eng_ack),
        .rdata_o   (eng_rdata),
        .fl_addr_o (fl_addr_o),
        .fl_dq_o   (fl_dq_o),
        .fl_we_o   (fl_we_o),
        .fl_oe_o   (fl_oe_o)
    );

    nes_poll_judge #(.POLL_LIMIT(POLL_LIMIT)) u_judge (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr_i      (accept),
        .sample_i   (eng_ack && (state == ST_POLL)),
        .status_i   (eng_rdata),
        .complete_o (st_complete),
        .limit_o    (st_limit),
        .last_o     (st_last)
    );

    // Operation state machine and result pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            step     <= '0;
            whole_q  <= 1'b0;
            base_q   <= '0;
            sector_q <= '0;
            issued   <= 1'b0;
            fail_q   <= 1'b0;
            done_o   <= 1'b0;
            error_o  <= 1'b0;
        end else begin
            done_o  <= 1'b0;
            error_o <= 1'b0;
            if (eng_req)
                issued <= 1'b1;
            else if (eng_ack)
                issued <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start_i) begin
                        whole_q  <= erase_all_i;
                        base_q   <= base_addr_i;
                        sector_q <= sector_addr_i;
                        step     <= '0;
                        fail_q   <= 1'b0;
                        state    <= ST_CMD;
                    end
                end
                ST_CMD: begin
                    if (eng_ack) begin
                        if (step == STEP_LAST)
                            state <= ST_POLL;
                        else
                            step <= step + 3'd1;
                    end
                end
                ST_POLL: begin
                    if (eng_ack) begin
                        if (st_complete) begin
                            state <= ST_RESET;
                        end else if (st_limit) begin
                            state <= ST_RECHECK;
                        end else if (st_last) begin
                            fail_q <= 1'b1;
                            state  <= ST_RESET;
                        end
                    end
                end
                ST_RECHECK: begin
                    if (eng_ack) begin
                        fail_q <= !st_complete;
                        state  <= ST_RESET;
                    end
                end
                ST_RESET: begin
                    if (eng_ack) begin
                        done_o  <= !fail_q;
                        error_o <= fail_q;
                        state   <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign busy_o = (state != ST_IDLE);

endmodule

// File: rtl/nes_checker.sv
// Checker for the NOR erase sequencer, attached by bind.
// Watches only the top-level ports; strobe widths use run counters.
module nes_checker #(
    parameter int ADDR_W   = 20,
    parameter int WR_PULSE = 3,
    parameter int RD_PULSE = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic              busy_o,
    input logic              done_o,
    input logic              error_o,
    input logic [ADDR_W-1:0] fl_addr_o,
    input logic [7:0]        fl_dq_o,
    input logic              fl_we_o,
    input logic              fl_oe_o
);
    logic [15:0] we_run;
    logic [15:0] oe_run;

    // Count the length of the current strobe runs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            we_run <= '0;
            oe_run <= '0;
        end else begin
            we_run <= fl_we_o ? we_run + 16'd1 : 16'd0;
            oe_run <= fl_oe_o ? oe_run + 16'd1 : 16'd0;
        end
    end

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (!fl_we_o && !fl_oe_o));

    assert_strobe_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(fl_we_o && fl_oe_o));

    assert_write_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (fl_we_o && we_run != 16'd0) |-> ($stable(fl_addr_o) && $stable(fl_dq_o)));

    assert_write_width_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!fl_we_o && we_run != 16'd0) |-> (we_run == 16'(WR_PULSE)));

    assert_strobe_gap_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!fl_we_o && !fl_oe_o && (we_run != 16'd0 || oe_run != 16'd0)) |=> (!fl_we_o && !fl_oe_o));

    assert_read_width_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!fl_oe_o && oe_run != 16'd0) |-> (oe_run == 16'(RD_PULSE)));

    assert_pulse_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_o && error_o));

    assert_done_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o || error_o) |=> (!done_o && !error_o));

    assert_busy_rise_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && start_i) |=> busy_o);

    assert_result_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o || error_o) |-> !busy_o);

endmodule

bind nor_erase_seq nes_checker #(
    .ADDR_W   (ADDR_W),
    .WR_PULSE (WR_PULSE),
    .RD_PULSE (RD_PULSE)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .busy_o    (busy_o),
    .done_o    (done_o),
    .error_o   (error_o),
    .fl_addr_o (fl_addr_o),
    .fl_dq_o   (fl_dq_o),
    .fl_we_o   (fl_we_o),
    .fl_oe_o   (fl_oe_o)
);

// File: tb/nor_erase_seq_tb.sv
// Bench: small configuration, behavioural status model, sweeps over
// modes, addresses and poll lengths with expected traffic computed here.
module nor_erase_seq_tb;
    localparam int AW    = 16;
    localparam int WP    = 2;
    localparam int RP    = 3;
    localparam int PLIM  = 6;
    localparam int WDOG  = 150000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic          erase_all_i = 1'b0;
    logic [AW-1:0] sector_addr_i = '0;
    logic [AW-1:0] base_addr_i = '0;
    logic          busy_o, done_o, error_o, fl_we_o, fl_oe_o;
    logic [AW-1:0] fl_addr_o;
    logic [7:0]    fl_dq_o;
    logic [7:0]    fl_dq_i;

    always #2.5 clk = ~clk;

    nor_erase_seq #(.ADDR_W(AW), .WR_PULSE(WP), .RD_PULSE(RP), .POLL_LIMIT(PLIM)) u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .erase_all_i(erase_all_i),
        .sector_addr_i(sector_addr_i), .base_addr_i(base_addr_i),
        .busy_o(busy_o), .done_o(done_o), .error_o(error_o),
        .fl_addr_o(fl_addr_o), .fl_dq_o(fl_dq_o), .fl_dq_i(fl_dq_i),
        .fl_we_o(fl_we_o), .fl_oe_o(fl_oe_o)
    );

    int n_chk = 0;
    int n_bad = 0;
    int cycles = 0;

    // status model: first busy_n reads return busy_byte, later ones final_byte
    int       busy_n = 0;
    logic [7:0] busy_byte = 8'h00;
    logic [7:0] final_byte = 8'h80;

    int        rd_cnt = 0, wr_cnt = 0, done_cnt = 0, err_cnt = 0;
    int        we_run = 0, oe_run = 0, width_bad = 0, rd_width_bad = 0, gap_bad = 0;
    int        rd_addr_bad = 0;
    logic [AW-1:0] poll_expect = '0;
    logic [AW-1:0] w_addr [16];
    logic [7:0]    w_data [16];
    logic [AW-1:0] cap_addr = '0;
    logic [7:0]    cap_data = '0;
    logic          prev_strobe = 1'b0;

    always_comb fl_dq_i = (rd_cnt < busy_n) ? busy_byte : final_byte;

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    // watchdog
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > WDOG) begin
            n_chk = n_chk + 1;
            n_bad = n_bad + 1;
            $display("FAIL watchdog: R11 actual=%0d cycles expected<=%0d", cycles, WDOG);
            summary();
        end
    end

    // bus monitor away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            if (fl_we_o) begin
                if (we_run == 0) begin
                    cap_addr = fl_addr_o;
                    cap_data = fl_dq_o;
                    if (prev_strobe) gap_bad = gap_bad + 1;
                end else if (cap_addr != fl_addr_o || cap_data != fl_dq_o) begin
                    width_bad = width_bad + 1;
                end
                we_run = we_run + 1;
            end else if (we_run != 0) begin
                if (we_run != WP) width_bad = width_bad + 1;
                if (wr_cnt < 16) begin
                    w_addr[wr_cnt] = cap_addr;
                    w_data[wr_cnt] = cap_data;
                end
                wr_cnt = wr_cnt + 1;
                we_run = 0;
            end
            if (fl_oe_o) begin
                if (oe_run == 0 && prev_strobe) gap_bad = gap_bad + 1;
                if (fl_addr_o != poll_expect) rd_addr_bad = rd_addr_bad + 1;
                oe_run = oe_run + 1;
            end else if (oe_run != 0) begin
                if (oe_run != RP) rd_width_bad = rd_width_bad + 1;
                rd_cnt = rd_cnt + 1;
                oe_run = 0;
            end
            if (fl_we_o && fl_oe_o) gap_bad = gap_bad + 1;
            prev_strobe = fl_we_o || fl_oe_o;
            if (done_o) done_cnt = done_cnt + 1;
            if (error_o) err_cnt = err_cnt + 1;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk = n_chk + 1;
        if (!ok) begin
            n_bad = n_bad + 1;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // one erase operation; outcome 0=done 1=error
    task automatic run_op(input bit whole, input logic [AW-1:0] base, input logic [AW-1:0] sec,
                          input int nbusy, input logic [7:0] bb, input logic [7:0] fb,
                          input int exp_reads, input bit exp_err, input bit poke);
        int guard;
        logic [AW-1:0] ea [7];
        logic [7:0]    ed [7];
        @(negedge clk);
        busy_n = nbusy; busy_byte = bb; final_byte = fb;
        rd_cnt = 0; wr_cnt = 0; done_cnt = 0; err_cnt = 0;
        width_bad = 0; rd_width_bad = 0; gap_bad = 0; rd_addr_bad = 0;
        poll_expect = whole ? base : sec;
        erase_all_i = whole; base_addr_i = base; sector_addr_i = sec; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        erase_all_i = !whole; sector_addr_i = sec ^ 16'h0F0F; base_addr_i = base ^ 16'h0100;
        chk(busy_o == 1'b1, "R11 busy after start", busy_o, 1);
        guard = 0;
        while (done_cnt + err_cnt == 0 && guard < 2000) begin
            if (poke && guard == 5) start_i = 1'b1;   // R11 start while busy
            if (poke && guard == 6) start_i = 1'b0;
            @(negedge clk);
            guard = guard + 1;
        end
        start_i = 1'b0;
        chk(busy_o == 1'b0, "R11 busy low with result", busy_o, 0);
        repeat (3) @(negedge clk);
        chk(done_cnt == (exp_err ? 0 : 1), "R11 done count", done_cnt, exp_err ? 0 : 1);
        chk(err_cnt == (exp_err ? 1 : 0), "R6/R7 error count", err_cnt, exp_err ? 1 : 0);
        chk(busy_o == 1'b0, "R11 idle after op", busy_o, 0);
        ea[0] = base + 16'h555; ed[0] = 8'hAA;
        ea[1] = base + 16'h2AA; ed[1] = 8'h55;
        ea[2] = base + 16'h555; ed[2] = 8'h80;
        ea[3] = base + 16'h555; ed[3] = 8'hAA;
        ea[4] = base + 16'h2AA; ed[4] = 8'h55;
        ea[5] = whole ? base + 16'h555 : sec;
        ed[5] = whole ? 8'h10 : 8'h30;
        ea[6] = base; ed[6] = 8'hF0;
        chk(wr_cnt == 7, "R8 write count", wr_cnt, 7);
        for (int i = 0; i < 5; i++) begin
            chk(w_addr[i] == ea[i] && w_data[i] == ed[i], "R2 unlock write",
                {w_addr[i], w_data[i]}, {ea[i], ed[i]});
        end
        if (whole)
            chk(w_addr[5] == ea[5] && w_data[5] == ed[5], "R3 chip command",
                {w_addr[5], w_data[5]}, {ea[5], ed[5]});
        else
            chk(w_addr[5] == ea[5] && w_data[5] == ed[5], "R4 sector command",
                {w_addr[5], w_data[5]}, {ea[5], ed[5]});
        chk(w_addr[6] == ea[6] && w_data[6] == ed[6], "R8 reset write",
            {w_addr[6], w_data[6]}, {ea[6], ed[6]});
        chk(rd_cnt == exp_reads, "R5 poll read count", rd_cnt, exp_reads);
        chk(rd_addr_bad == 0, "R5 poll address", rd_addr_bad, 0);
        chk(width_bad == 0 && gap_bad == 0, "R9 write strobe shape", width_bad + gap_bad, 0);
        chk(rd_width_bad == 0, "R10 read strobe width", rd_width_bad, 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        chk(busy_o == 0 && done_o == 0 && error_o == 0, "R1 reset outputs",
            {busy_o, done_o, error_o}, 0);
        chk(fl_we_o == 0 && fl_oe_o == 0, "R1 reset strobes", {fl_we_o, fl_oe_o}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(busy_o == 0 && fl_we_o == 0 && fl_oe_o == 0, "R1 idle after reset",
            {busy_o, fl_we_o, fl_oe_o}, 0);
        // R5 sweep: both modes, several addresses, 0..3 busy reads
        for (int m = 0; m < 2; m++) begin
            for (int a = 0; a < 2; a++) begin
                for (int k = 0; k < 4; k++) begin
                    run_op(m[0], a[0] ? 16'h4000 : 16'h0000,
                           a[0] ? 16'hC123 : 16'h1000 + 16'(k),
                           k, 8'h40 ^ 8'(k), 8'hFF, k + 1, 1'b0, 1'b0);
                end
            end
        end
        // R6 time-limit bit then good recheck, both modes
        run_op(1'b0, 16'h2000, 16'h3456, 1, 8'h20, 8'h80, 2, 1'b0, 1'b0);
        run_op(1'b1, 16'h2000, 16'h3456, 1, 8'h60, 8'hA0, 2, 1'b0, 1'b0);
        // R6 time-limit bit then bad recheck
        run_op(1'b0, 16'h0800, 16'h9000, 1, 8'h20, 8'h20, 2, 1'b1, 1'b0);
        run_op(1'b1, 16'h0800, 16'h9000, 2, 8'h00, 8'h20, 4, 1'b1, 1'b0);
        // R7 never completes: read cap
        run_op(1'b0, 16'h0000, 16'h5000, 100, 8'h00, 8'h00, PLIM, 1'b1, 1'b0);
        run_op(1'b1, 16'hFF00, 16'h5000, 100, 8'h4C, 8'h00, PLIM, 1'b1, 1'b0);
        // R11 start while busy ignored (also wraps base+offset)
        run_op(1'b0, 16'hFE00, 16'h7777, 2, 8'h00, 8'h80, 3, 1'b0, 1'b1);
        run_op(1'b1, 16'h1000, 16'h7777, 0, 8'h00, 8'h80, 1, 1'b0, 1'b1);
        summary();
    end

endmodule